// File: doc/BRIEF.md
# Reorder Buffer with Head-Side Branch Recovery

This block keeps in-flight instructions in program order so that an out-of-order core can commit them precisely. Each instruction takes the slot at the tail when it is dispatched and receives that slot index as its tag. Functional units later report completion against the tag, in any order. The entry at the head is retired once it is complete, and at most one entry retires per cycle. A retired entry drives commit strobes: one for architectural register updates and one for store writes to memory. The register file and the memory are outside this block.

Branches use static prediction. A negative offset is predicted taken and any other offset is predicted not taken. The predicted direction goes back to the front end during the dispatch cycle. The block records the address that was not predicted. A branch that resolves against its prediction does not trigger recovery at once. Recovery waits until the branch reaches the head, exactly as an exception does. The branch then commits, every younger entry is discarded, and the recorded address is driven as the redirect. A faulting entry at the head never commits. It flushes the whole buffer, itself included, and redirects to a fixed trap vector. HALT needs no execution unit. Once it retires, it freezes the machine.

Top module: `rob_core`

## Requirements
- R1: `disp_pred_taken` equals bit PC_W-1 (the sign) of `disp_offset`, combinationally and in the same cycle. A negative offset is predicted taken; zero and positive offsets are predicted not taken.
- R2: Dispatch tags are handed out consecutively as `disp_tag`, wrapping modulo DEPTH (default 16). `disp_ready` falls when DEPTH entries are in flight or the machine is halted. A `disp_valid` pulse while `disp_ready` is low leaves `disp_tag` unchanged.
- R3: Entries retire strictly in dispatch order, at most one per cycle, and only when the head entry has completed. A younger entry that completes first stays in the buffer until every older entry has retired.
- R4: During a retirement, `ret_tag`, `ret_kind`, `ret_dest` and `ret_result` show the head's tag, the kind and destination recorded at dispatch, and the result recorded at completion.
- R5: `ret_store` is high only while an entry of kind 1 (store) retires. Kind encoding: 0 register-writing operation, 1 store, 2 branch, 3 HALT.
- R6: A branch whose reported direction (`cmp_taken`) differs from its prediction raises `flush` only once it is the complete head entry. In that same cycle it retires (`ret_valid` high). `redirect_pc` is `pc + offset` if the branch was taken and `pc + 4` if it was not. All younger entries are discarded, and the next dispatch gets the tag one past the branch.
- R7: A branch resolved in its predicted direction retires without `flush`.
- R8: A completed head entry reported with `cmp_fault` does not retire: `ret_valid` and `ret_store` stay low. It raises `flush` with `redirect_pc` equal to TRAP_VEC, empties the buffer, and the next dispatch reuses the faulting entry's tag.
- R9: A HALT entry is complete from dispatch. When it retires, `halted` rises and stays high. After that nothing retires and `disp_ready` stays low.
- R10: A completion whose tag is not in flight, for example one discarded by a flush, has no effect.
- R11: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, and `ret_valid`, `flush` and `halted` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Kind of dispatched instruction |
| disp_dest | input | AREG_W | Architectural destination register |
| disp_pc | input | PC_W | Address of the dispatched instruction |
| disp_offset | input | PC_W | Signed branch offset |
| disp_ready | output | 1 | A dispatch this cycle will be accepted |
| disp_tag | output | TAG_W | Tag assigned to the dispatch |
| disp_pred_taken | output | 1 | Static branch prediction |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | TAG_W | Tag being completed |
| cmp_result | input | DATA_W | Result value |
| cmp_taken | input | 1 | Resolved branch direction |
| cmp_fault | input | 1 | Instruction raised an exception |
| ret_valid | output | 1 | Head entry commits this cycle |
| ret_tag | output | TAG_W | Tag of the head entry |
| ret_kind | output | 2 | Kind of the head entry |
| ret_dest | output | AREG_W | Destination of the head entry |
| ret_result | output | DATA_W | Result of the head entry |
| ret_store | output | 1 | Store commit strobe to memory |
| flush | output | 1 | Discard entries and redirect fetch |
| redirect_pc | output | PC_W | Fetch restart address |
| halted | output | 1 | HALT has retired |

## Verification
Several properties are checked every cycle by the assertions. The occupancy never exceeds DEPTH. Each retirement that does not flush advances the head by exactly one. Every flush leaves the buffer empty with nothing retiring in the following cycle. A full buffer never moves its tail. A raised `halted` never clears and blocks further commits. Other behaviours can only be shown by the bench's scenarios: the exact redirect addresses for both mispredict directions, the trap vector, tag reuse after a fault or a mispredict, a late completion to a discarded tag being dropped, strict order when completions arrive out of order, and the prediction for boundary offsets.

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH = 16,
  parameter int PC_W = 32,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  parameter int INSN_BYTES = 4,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [1:0]        disp_kind,
  input  logic [AREG_W-1:0] disp_dest,
  input  logic [PC_W-1:0]   disp_pc,
  input  logic [PC_W-1:0]   disp_offset,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  output logic              disp_pred_taken,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_result,
  input  logic              cmp_taken,
  input  logic              cmp_fault,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [1:0]        ret_kind,
  output logic [AREG_W-1:0] ret_dest,
  output logic [DATA_W-1:0] ret_result,
  output logic              ret_store,
  output logic              flush,
  output logic [PC_W-1:0]   redirect_pc,
  output logic              halted
);
  localparam logic [1:0] K_STORE = 2'd1, K_BRANCH = 2'd2, K_HALT = 2'd3;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  vld, done, bad, mis, pred;
  logic [1:0]        kind   [DEPTH];
  logic [AREG_W-1:0] dest   [DEPTH];
  logic [DATA_W-1:0] result [DEPTH];
  logic [PC_W-1:0]   alt_pc [DEPTH];

  logic head_ready, acc, cmp_fire;

  assign disp_pred_taken = disp_offset[PC_W-1];
  assign disp_ready      = (count != FULL) && !halted;
  assign disp_tag        = tail;
  assign head_ready      = vld[head] && done[head] && !halted;
  assign flush           = head_ready && (bad[head] || mis[head]);
  assign ret_valid       = head_ready && !bad[head];
  assign acc             = disp_valid && disp_ready && !flush;
  assign cmp_fire        = cmp_valid && vld[cmp_tag] && !done[cmp_tag];
  assign ret_tag         = head;
  assign ret_kind        = kind[head];
  assign ret_dest        = dest[head];
  assign ret_result      = result[head];
  assign ret_store       = ret_valid && (kind[head] == K_STORE);
  assign redirect_pc     = bad[head] ? TRAP_VEC : alt_pc[head];

  always_ff @(posedge clk) begin
    if (acc) begin
      kind[tail]   <= disp_kind;
      dest[tail]   <= disp_dest;
      alt_pc[tail] <= disp_pred_taken ? disp_pc + PC_W'(INSN_BYTES)
                                      : disp_pc + disp_offset;
    end
    if (cmp_fire) result[cmp_tag] <= cmp_result;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      vld    <= '0;
      done   <= '0;
      bad    <= '0;
      mis    <= '0;
      pred   <= '0;
      halted <= 1'b0;
    end else begin
      if (cmp_fire) begin
        done[cmp_tag] <= 1'b1;
        bad[cmp_tag]  <= cmp_fault;
        mis[cmp_tag]  <= (kind[cmp_tag] == K_BRANCH) && (cmp_taken != pred[cmp_tag]);
      end
      if (flush) begin
        vld   <= '0;
        count <= '0;
        if (bad[head]) begin
          tail <= head;
        end else begin
          head <= head + ONE;
          tail <= head + ONE;
        end
      end else begin
        if (ret_valid) begin
          vld[head] <= 1'b0;
          head      <= head + ONE;
          if (kind[head] == K_HALT) halted <= 1'b1;
        end
        if (acc) begin
          vld[tail]  <= 1'b1;
          done[tail] <= (disp_kind == K_HALT);
          bad[tail]  <= 1'b0;
          mis[tail]  <= 1'b0;
          pred[tail] <= disp_pred_taken;
          tail       <= tail + ONE;
        end
        count <= count + CNT_W'(acc) - CNT_W'(ret_valid);
      end
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  assert_full_holds_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && !flush) |=> tail == $past(tail));
  assert_head_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush) |=> head == TAG_W'($past(head) + ONE));
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !ret_valid);
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !ret_valid && !disp_ready);
endmodule

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [1:0] disp_kind = '0;
  logic [4:0] disp_dest = '0;
  logic [31:0] disp_pc = '0, disp_offset = '0;
  logic disp_ready, disp_pred_taken;
  logic [3:0] disp_tag;
  logic cmp_valid = 1'b0, cmp_taken = 1'b0, cmp_fault = 1'b0;
  logic [3:0] cmp_tag = '0;
  logic [31:0] cmp_result = '0;
  logic ret_valid, ret_store, flush, halted;
  logic [3:0] ret_tag;
  logic [1:0] ret_kind;
  logic [4:0] ret_dest;
  logic [31:0] ret_result, redirect_pc;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rob_core dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_kind(disp_kind),
    .disp_dest(disp_dest), .disp_pc(disp_pc), .disp_offset(disp_offset),
    .disp_ready(disp_ready), .disp_tag(disp_tag), .disp_pred_taken(disp_pred_taken),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_result(cmp_result),
    .cmp_taken(cmp_taken), .cmp_fault(cmp_fault), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .ret_kind(ret_kind), .ret_dest(ret_dest),
    .ret_result(ret_result), .ret_store(ret_store), .flush(flush),
    .redirect_pc(redirect_pc), .halted(halted)
  );

  // offset, expected prediction (R1)
  localparam logic [32:0] PRED_VEC [6] = '{
    {32'hFFFF_FFF8, 1'b1}, {32'h0000_0008, 1'b0}, {32'h0000_0000, 1'b0},
    {32'h7FFF_FFFF, 1'b0}, {32'h8000_0000, 1'b1}, {32'hFFFF_FFFF, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    disp_valid = 1'b0;
    cmp_valid = 1'b0;
    cmp_fault = 1'b0;
    cmp_taken = 1'b0;
  endtask

  task automatic disp(logic [1:0] k, logic [4:0] d, logic [31:0] pc, logic [31:0] off,
                      logic [3:0] exp_tag);
    disp_valid = 1'b1; disp_kind = k; disp_dest = d; disp_pc = pc; disp_offset = off;
    check("R2 tag", 32'(disp_tag), 32'(exp_tag));
    check("R2 ready", 32'(disp_ready), 32'd1);
    tick();
  endtask

  task automatic cmpl(logic [3:0] t, logic [31:0] res, logic tk, logic flt);
    cmp_valid = 1'b1; cmp_tag = t; cmp_result = res; cmp_taken = tk; cmp_fault = flt;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 ready", 32'(disp_ready), 32'd1);
    check("R11 tag", 32'(disp_tag), 32'd0);
    check("R11 ret", 32'(ret_valid), 32'd0);
    check("R11 flush", 32'(flush), 32'd0);
    check("R11 halted", 32'(halted), 32'd0);

    for (int i = 0; i < 6; i++) begin
      disp_offset = PRED_VEC[i][32:1];
      #1;
      check("R1 prediction", 32'(disp_pred_taken), 32'(PRED_VEC[i][0]));
    end
    tick();

    // R3/R4: out-of-order completion, in-order retirement
    disp(2'd0, 5'd5, 32'h10, 32'h0, 4'd0);
    disp(2'd0, 5'd6, 32'h14, 32'h0, 4'd1);
    disp(2'd0, 5'd7, 32'h18, 32'h0, 4'd2);
    cmpl(4'd2, 32'h22, 1'b0, 1'b0);
    check("R3 young done no retire", 32'(ret_valid), 32'd0);
    cmpl(4'd0, 32'h11, 1'b0, 1'b0);
    check("R3 head retires", 32'(ret_valid), 32'd1);
    check("R4 tag", 32'(ret_tag), 32'd0);
    check("R4 dest", 32'(ret_dest), 32'd5);
    check("R4 result", ret_result, 32'h11);
    check("R4 kind", 32'(ret_kind), 32'd0);
    check("R5 no store", 32'(ret_store), 32'd0);
    tick();
    check("R3 waits on tag1", 32'(ret_valid), 32'd0);
    cmpl(4'd1, 32'h33, 1'b0, 1'b0);
    check("R3 tag1", 32'(ret_tag), 32'd1);
    tick();
    check("R3 tag2 next cycle", 32'(ret_valid), 32'd1);
    check("R3 tag2", 32'(ret_tag), 32'd2);
    check("R4 tag2 result", ret_result, 32'h22);
    tick();
    check("R3 empty", 32'(ret_valid), 32'd0);

    // R5 store commit
    disp(2'd1, 5'd0, 32'h1C, 32'h0, 4'd3);
    cmpl(4'd3, 32'h0, 1'b0, 1'b0);
    check("R5 store strobe", 32'(ret_store), 32'd1);
    tick();
    check("R5 strobe drops", 32'(ret_store), 32'd0);

    // R7 correctly predicted taken branch
    disp_offset = 32'hFFFF_FFF8; #1;
    check("R1 backward taken", 32'(disp_pred_taken), 32'd1);
    disp(2'd2, 5'd0, 32'h100, 32'hFFFF_FFF8, 4'd4);
    disp(2'd0, 5'd3, 32'h104, 32'h0, 4'd5);
    cmpl(4'd4, 32'h0, 1'b1, 1'b0);
    check("R7 retire", 32'(ret_valid), 32'd1);
    check("R7 no flush", 32'(flush), 32'd0);
    tick();
    cmpl(4'd5, 32'h55, 1'b0, 1'b0);
    check("R7 younger kept", 32'(ret_tag), 32'd5);
    tick();

    // R6 forward branch predicted not taken, actually taken
    disp(2'd2, 5'd0, 32'h200, 32'h40, 4'd6);
    disp(2'd0, 5'd1, 32'h204, 32'h0, 4'd7);
    disp(2'd0, 5'd2, 32'h208, 32'h0, 4'd8);
    cmpl(4'd7, 32'h77, 1'b0, 1'b0);
    check("R6 no early flush", 32'(flush), 32'd0);
    cmpl(4'd6, 32'h0, 1'b1, 1'b0);
    check("R6 flush at head", 32'(flush), 32'd1);
    check("R6 branch commits", 32'(ret_valid), 32'd1);
    check("R6 redirect taken", redirect_pc, 32'h240);
    tick();
    check("R6 next tag", 32'(disp_tag), 32'd7);
    check("R6 younger discarded", 32'(ret_valid), 32'd0);
    cmpl(4'd8, 32'h88, 1'b0, 1'b0);
    check("R10 stale completion", 32'(ret_valid), 32'd0);
    check("R10 tail unchanged", 32'(disp_tag), 32'd7);

    // R6 backward branch predicted taken, actually not taken
    disp(2'd2, 5'd0, 32'h300, 32'hFFFF_FFF0, 4'd7);
    cmpl(4'd7, 32'h0, 1'b0, 1'b0);
    check("R6 flush nt", 32'(flush), 32'd1);
    check("R6 redirect fallthrough", redirect_pc, 32'h304);
    tick();
    check("R6 tag after", 32'(disp_tag), 32'd8);

    // R8 faulting store
    disp(2'd1, 5'd0, 32'h400, 32'h0, 4'd8);
    disp(2'd0, 5'd4, 32'h404, 32'h0, 4'd9);
    cmpl(4'd8, 32'h0, 1'b0, 1'b1);
    check("R8 flush", 32'(flush), 32'd1);
    check("R8 no retire", 32'(ret_valid), 32'd0);
    check("R8 no store", 32'(ret_store), 32'd0);
    check("R8 trap vector", redirect_pc, 32'h80);
    tick();
    check("R8 tag reused", 32'(disp_tag), 32'd8);
    check("R8 empty", 32'(ret_valid), 32'd0);

    // R2 fill to capacity, wrap, ignored dispatch
    for (int i = 0; i < 16; i++)
      disp(2'd0, 5'(i), 32'h500, 32'h0, 4'((8 + i) % 16));
    check("R2 full not ready", 32'(disp_ready), 32'd0);
    disp_valid = 1'b1; disp_kind = 2'd0;
    tick();
    cmpl(4'd8, 32'h0, 1'b0, 1'b0);
    check("R2 still full", 32'(disp_ready), 32'd0);
    check("R3 head 8", 32'(ret_tag), 32'd8);
    tick();
    check("R2 ignored dispatch", 32'(disp_tag), 32'd8);
    disp(2'd3, 5'd0, 32'h600, 32'h0, 4'd8);
    for (int i = 1; i < 16; i++) begin
      cmpl(4'((8 + i) % 16), 32'(i), 1'b0, 1'b0);
      check("R3 order", 32'(ret_tag), 32'((8 + i) % 16));
    end
    tick();
    check("R9 halt retires", 32'(ret_valid), 32'd1);
    check("R9 halt kind", 32'(ret_kind), 32'd3);
    check("R9 halt tag", 32'(ret_tag), 32'd8);
    tick();
    check("R9 halted", 32'(halted), 32'd1);
    check("R9 dispatch blocked", 32'(disp_ready), 32'd0);
    disp_valid = 1'b1;
    tick();
    check("R9 stays halted", 32'(halted), 32'd1);
    check("R9 no retire", 32'(ret_valid), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule